// File: doc/BRIEF.md
# Level-Source Interrupt Hub with Claim and Complete

This block collects level-triggered requests from a small set of sources and presents them to a single target. Each source passes through its own gateway. The gateway forwards one request, then refuses any further request from that source until software declares the handler finished. Forwarded requests are held as pending bits. Each source has a priority. The target has an enable bit per source and a priority threshold. The target interrupt line is raised whenever an enabled pending source has a priority above the threshold.

Software uses a single register port with valid, write, address and data. A read of the claim/complete word returns the ID of the best eligible source and consumes its pending bit in the same cycle. After the handler runs, software writes that ID back to the same word. A completion is honoured only when the ID names a source whose enable bit is currently set. If a source is disabled while it is in service, its completion is dropped and the source stays blocked. It stays blocked until it is enabled again and completed again.

The register port has no back-pressure. A request is accepted on every cycle in which `bus_valid_i` is high. Read data appears one cycle later, marked by `bus_rvalid_o`, and is never stalled.

Top module: `irq_hub`

## Requirements
- R1: After reset, all priority, pending, enable and threshold words read 0. A claim read returns 0 and `irq_o` is low.
- R2: Register map (word addresses). Source n (1..7) has its priority in the low 3 bits of address n. Address 8 is the pending bitmap, with bit n for source n. Address 9 is the enable bitmap, with bit n for source n; bit 0 always reads 0. Address 10 is the threshold. Address 11 is claim/complete. Any other address reads 0.
- R3: A source whose level input is high and whose gateway is idle sets its pending bit at the next clock edge. Writes to the pending bitmap change nothing.
- R4: `irq_o` is high exactly when some source is pending and enabled and has a priority strictly above the threshold. A source with priority 0 therefore never raises it.
- R5: A claim read returns the highest-priority eligible source, and ties go to the lowest ID. That source's pending bit clears at the same edge that registers the read. The data is presented with `bus_rvalid_o` one cycle after the request.
- R6: A claim read returns 0 when no source is eligible.
- R7: Once a source is forwarded, its gateway sets no further pending bit for that source until that source is validly completed, even if its level input stays high.
- R8: A completion write of an ID n in 1..7 with enable bit n set returns gateway n to idle, whatever ID was claimed last. If the level is still high, pending n sets at the edge after the completion edge.
- R9: A completion write of 0, of an ID above 7, or of a disabled ID has no effect. A source disabled during service therefore stays blocked until it is re-enabled and completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC (7) | Level request per source, bit n is source n |
| bus_valid_i | input | 1 | Register access request, accepted every cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt line to the target |

## Verification
The assertions assume that every register request is a single-cycle pulse and that write data for the enable word fits the source count. They also assume that `src_i` changes only between clock edges and has no glitches. The bench drives all inputs on falling edges and holds each request for exactly one cycle. It issues back-to-back accesses only where the one-cycle gap between a completion and a new pending bit is the subject of the check. Level inputs are raised at least one cycle before any read that relies on the pending bits.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } reg_sel_e;

  // blk is the first address after the priority words
  function automatic reg_sel_e decode_sel(int unsigned addr, int unsigned nsrc,
                                          int unsigned blk);
    if (addr >= 1 && addr <= nsrc) return SEL_PRIO;
    if (addr == blk)               return SEL_PEND;
    if (addr == blk + 1)           return SEL_EN;
    if (addr == blk + 2)           return SEL_THR;
    if (addr == blk + 3)           return SEL_CLAIM;
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/irq_hub_gateway.sv
module irq_hub_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic busy_o
);
  logic fwd;

  assign fwd = level_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      if (complete_i)  busy_o <= 1'b0;
      else if (fwd)    busy_o <= 1'b1;
      if (claim_i)     pending_o <= 1'b0;
      else if (fwd)    pending_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_hub_arbiter.sv
module irq_hub_arbiter #(
  parameter int NSRC   = 7,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC + 1)
) (
  input  logic [NSRC:0]             pend_i,
  input  logic [NSRC:0]             en_i,
  input  logic [NSRC:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic [ID_W-1:0]           best_id_o,
  output logic                      irq_o
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_id_o = '0;
    best_p    = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (pend_i[i] && en_i[i] && prio_i[i] > thr_i && prio_i[i] > best_p) begin
        best_id_o = ID_W'(i);
        best_p    = prio_i[i];
      end
    end
  end

  assign irq_o = best_id_o != '0;
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC   = 7,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  localparam int ID_W   = $clog2(NSRC + 1),
  localparam int ADDR_W = ID_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC:1]     src_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  import irq_hub_pkg::*;

  localparam int BLK = 1 << ID_W;

  logic [NSRC:0][PRIO_W-1:0] prio_q;
  logic [NSRC:0]             en_q;
  logic [PRIO_W-1:0]         thr_q;
  logic [NSRC:0]             pend;
  logic [NSRC:0]             busy;
  logic [ID_W-1:0]           best_id;
  reg_sel_e                  sel;
  logic                      rd_claim, wr_cmp, cmp_hit;
  logic [ID_W-1:0]           cmp_id;
  logic [ID_W-1:0]           prio_idx;

  assign sel      = decode_sel(int'(bus_addr_i), NSRC, BLK);
  assign rd_claim = bus_valid_i && !bus_write_i && sel == SEL_CLAIM;
  assign wr_cmp   = bus_valid_i && bus_write_i && sel == SEL_CLAIM;
  assign cmp_id   = bus_wdata_i[ID_W-1:0];
  assign cmp_hit  = wr_cmp && bus_wdata_i != '0 &&
                    bus_wdata_i <= DATA_W'(NSRC) && en_q[cmp_id];
  assign prio_idx = bus_addr_i[ID_W-1:0];

  assign pend[0] = 1'b0;
  assign busy[0] = 1'b0;

  for (genvar g = 1; g <= NSRC; g++) begin : g_gw
    irq_hub_gateway u_gw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .level_i    (src_i[g]),
      .claim_i    (rd_claim && best_id == ID_W'(g)),
      .complete_i (cmp_hit && cmp_id == ID_W'(g)),
      .pending_o  (pend[g]),
      .busy_o     (busy[g])
    );
  end

  irq_hub_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_i    (pend),
    .en_i      (en_q),
    .prio_i    (prio_q),
    .thr_i     (thr_q),
    .best_id_o (best_id),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (bus_valid_i && bus_write_i) begin
      case (sel)
        SEL_PRIO: prio_q[prio_idx] <= bus_wdata_i[PRIO_W-1:0];
        SEL_EN:   en_q <= {bus_wdata_i[NSRC:1], 1'b0};
        SEL_THR:  thr_q <= bus_wdata_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= bus_valid_i && !bus_write_i;
      if (bus_valid_i && !bus_write_i) begin
        case (sel)
          SEL_PRIO:  bus_rdata_o <= DATA_W'(prio_q[prio_idx]);
          SEL_PEND:  bus_rdata_o <= DATA_W'(pend);
          SEL_EN:    bus_rdata_o <= DATA_W'(en_q);
          SEL_THR:   bus_rdata_o <= DATA_W'(thr_q);
          SEL_CLAIM: bus_rdata_o <= DATA_W'(best_id);
          default:   bus_rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NSRC   = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              bus_rvalid_o,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_o,
  input logic [NSRC:0]     pend,
  input logic [NSRC:0]     en_q,
  input logic [NSRC:0]     busy
);
  localparam int ID_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] A_CLAIM = ADDR_W'((1 << ID_W) + 3);

  logic claim_q;
  logic cmp_w;
  logic [NSRC:0] accept;

  assign cmp_w = bus_valid_i && bus_write_i && bus_addr_i == A_CLAIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) claim_q <= 1'b0;
    else         claim_q <= bus_valid_i && !bus_write_i && bus_addr_i == A_CLAIM;
  end

  assign accept[0] = 1'b0;
  for (genvar g = 1; g <= NSRC; g++) begin : g_src
    assign accept[g] = cmp_w && bus_wdata_i == DATA_W'(g) && en_q[g];

    // R7 and R9: a busy gateway stays busy unless an accepted completion names it
    p_blocked_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy[g] && !accept[g] |=> busy[g]);

    // R8: an accepted completion frees the gateway
    p_complete_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept[g] |=> !busy[g]);

    // R3: a new pending bit only comes from an idle gateway
    p_pend_from_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend[g]) |-> $past(!busy[g]));
  end

  // R5: claimed ID is in range and its pending bit is already clear
  p_claim_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_q && bus_rvalid_o |-> bus_rdata_o <= DATA_W'(NSRC));

  p_claim_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_q && bus_rvalid_o && bus_rdata_o != '0 |-> !pend[bus_rdata_o[ID_W-1:0]]);

  // R4: the line needs at least one enabled pending source
  p_irq_needs_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend & en_q) != '0);
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rvalid_o (bus_rvalid_o),
  .bus_rdata_o  (bus_rdata_o),
  .irq_o        (irq_o),
  .pend         (pend),
  .en_q         (en_q),
  .busy         (busy)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;
  localparam int NSRC = 7;
  localparam int A_PEND = 8, A_EN = 9, A_THR = 10, A_CLM = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NSRC:1] src = '0;
  logic        valid = 1'b0, write = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_hub i_irq_hub (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .src_i        (src),
    .bus_valid_i  (valid),
    .bus_write_i  (write),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rvalid_o (rvalid),
    .bus_rdata_o  (rdata),
    .irq_o        (irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // all helpers start and end just after a falling edge
  task automatic wr(int a, logic [31:0] d);
    valid = 1'b1; write = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    valid = 1'b1; write = 1'b0; addr = 4'(a);
    @(negedge clk);
    valid = 1'b0;
    d = rvalid ? rdata : 32'hDEAD_BEEF;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src = '0; valid = 1'b0; write = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset_map();
    logic [31:0] d;
    do_reset();
    rd(1, d);      chk("R1 prio1", d, 0);
    rd(7, d);      chk("R1 prio7", d, 0);
    rd(A_PEND, d); chk("R1 pend", d, 0);
    rd(A_EN, d);   chk("R1 en", d, 0);
    rd(A_THR, d);  chk("R1 thr", d, 0);
    rd(A_CLM, d);  chk("R1 claim", d, 0);
    chk("R1 irq", 32'(irq), 0);
    wr(A_EN, 32'hFF);
    rd(A_EN, d);   chk("R2 enable bit0 reads 0", d, 32'hFE);
    wr(3, 32'hD);
    rd(3, d);      chk("R2 prio low bits", d, 32'h5);
    rd(12, d);     chk("R2 unmapped address", d, 0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    do_reset();
    src[3] = 1'b1;
    idle(1);
    rd(A_PEND, d); chk("R3 pending set", d, 32'h08);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); chk("R3 pending write ignored", d, 32'h08);
    chk("R4 irq low while disabled", 32'(irq), 0);
    rd(A_CLM, d);  chk("R6 claim none enabled", d, 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    do_reset();
    wr(1, 2); wr(2, 5); wr(4, 5); wr(6, 0);
    wr(A_EN, 32'hFE);
    src = 7'b0101011;
    idle(1);
    chk("R4 irq high", 32'(irq), 1);
    rd(A_CLM, d);  chk("R5 tie lowest id", d, 2);
    rd(A_PEND, d); chk("R5 claimed bit cleared", d, 32'h52);
    rd(A_CLM, d);  chk("R5 next tie", d, 4);
    rd(A_CLM, d);  chk("R5 lower prio", d, 1);
    rd(A_CLM, d);  chk("R6 prio zero never claimed", d, 0);
    chk("R4 prio zero no irq", 32'(irq), 0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    do_reset();
    wr(5, 3); wr(A_EN, 32'h20); wr(A_THR, 3);
    src[5] = 1'b1;
    idle(1);
    chk("R4 equal to threshold no irq", 32'(irq), 0);
    rd(A_CLM, d);  chk("R6 below threshold claim", d, 0);
    wr(A_THR, 2);
    chk("R4 above threshold irq", 32'(irq), 1);
    rd(A_CLM, d);  chk("R5 claim above threshold", d, 5);
  endtask

  task automatic t_block_complete();
    logic [31:0] d;
    do_reset();
    wr(2, 1); wr(3, 1); wr(A_EN, 32'h0C);
    src[2] = 1'b1; src[3] = 1'b1;
    idle(1);
    rd(A_CLM, d);  chk("R5 claim 2", d, 2);
    rd(A_CLM, d);  chk("R5 claim 3", d, 3);
    idle(3);
    rd(A_PEND, d); chk("R7 in service stays clear", d, 0);
    wr(A_CLM, 2);
    rd(A_PEND, d); chk("R8 not yet re-pending", d, 0);
    rd(A_PEND, d); chk("R8 re-pending after complete", d, 32'h04);
  endtask

  task automatic t_disabled_complete();
    logic [31:0] d;
    do_reset();
    wr(5, 1); wr(A_EN, 32'h20);
    src[5] = 1'b1;
    idle(1);
    rd(A_CLM, d);  chk("R5 claim 5", d, 5);
    wr(A_EN, 0);
    wr(A_CLM, 5);
    wr(A_EN, 32'h20);
    idle(2);
    rd(A_PEND, d); chk("R9 disabled completion dropped", d, 0);
    rd(A_CLM, d);  chk("R9 source stays blocked", d, 0);
    wr(A_CLM, 0);
    wr(A_CLM, 9);
    idle(1);
    rd(A_PEND, d); chk("R9 id 0 and out of range dropped", d, 0);
    wr(A_CLM, 5);
    idle(1);
    rd(A_PEND, d); chk("R8 recovered after re-enable", d, 32'h20);
    chk("R4 irq after recovery", 32'(irq), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(1);
    t_reset_map();
    t_pending();
    t_priority();
    t_threshold();
    t_block_complete();
    t_disabled_complete();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule